// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and turns them into two processor requests: a normal interrupt request and a fast interrupt request. Each source input is ORed with a bit that software can set, which gives one shared raw status word. Two independent enable words mask that raw status. One produces the normal request and the other produces the fast request. Both requests are registered, and each is the OR of its masked status. Because there is no pending latch for hardware inputs, a request stays up exactly as long as an enabled source holds its line high.

Software uses a small word-addressed register port with an address, a write strobe, write data and combinational read data. Enables and software bits are never written directly. Each has one address where ones set bits and a second address where ones clear bits, so two agents never need a read-modify-write. A build-time mask marks which source positions exist. When the block is built as a secondary controller, it also holds a pass-through enable word. That word sends chosen raw inputs straight to an output bus, bypassing both masks.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, both enable words, the software bits and the pass-through word are zero, `irq_o`, `fiq_o` and `pass_o` are low, and reads of offsets 0x00 and 0x28 return zero.
- R2: Raw status equals (`src_in` OR software bits) AND `VALID_MASK`. It is read at byte offset 0x04 and also at 0x24.
- R3: A write to offset 0x08 sets every normal-enable bit that is one in the write data, and a write to 0x0C clears every such bit. Bits written as zero keep their value.
- R4: Offset 0x00 reads raw status AND the normal-enable word.
- R5: A write to 0x10 sets the software bits that are one in the data, and a write to 0x14 clears them. Zero bits keep their value.
- R6: A write to 0x28 sets fast-enable bits and a write to 0x2C clears them. A read of 0x28 returns the fast-enable word as stored, and a read of 0x20 returns raw status AND the fast-enable word.
- R7: `irq_o` (and `fiq_o`) equals the OR of the normal (fast) masked status one clock edge earlier. It falls one edge after the last enabled source drops, with no latching.
- R8: A source position that is zero in `VALID_MASK` reads zero in every status word. It never raises `irq_o`, `fiq_o` or `pass_o`, whether driven by a source input or by a software bit.
- R9: With `SECONDARY` set, a write to 0x20 loads the whole pass-through word. `pass_o` combinationally equals `src_in` AND `VALID_MASK` AND that word, and the write leaves the fast-enable word unchanged.
- R10: Reads of any offset other than 0x00, 0x04, 0x20, 0x24 and 0x28 return zero. This includes offsets whose two low bits are non-zero. Writes to any offset other than 0x08, 0x0C, 0x10, 0x14, 0x20, 0x28 and 0x2C change no state.
- R11: A register write takes effect at the clock edge where `bus_we` is sampled high, and a read after that edge shows the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Combinational read data for `bus_addr` |
| src_in | input | NSRC | Level-sensitive interrupt source lines |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| pass_o | output | NSRC | Combinational pass-through of selected sources |

## Verification
The bench builds the controller with two source positions marked invalid. A single source is walked across all 32 positions, first with every enable off and then with every enable on. This separates raw from masked status, shows that each bit lands at its own position, and shows that the invalid positions stay silent on every output. Mixed set and clear patterns on the enable and software words show that zero bits in the write data are left alone. A one-cycle timing probe on the fast request, together with dropping the source, separates a registered level request from a combinational or latched one. A sweep of every read offset, followed by writes of all ones to read-only and unaligned offsets, shows the address decoding is exact.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Register offsets and the write-strobe bundle shared by the controller's
// sub-blocks. Offsets are byte offsets. Only word-aligned values are decoded.
package irqc_pkg;

    localparam logic [7:0] OFS_IRQ_MSK  = 8'h00;  // read: raw & normal enable
    localparam logic [7:0] OFS_RAW      = 8'h04;  // read: raw status
    localparam logic [7:0] OFS_IRQ_SET  = 8'h08;  // write: set normal enables
    localparam logic [7:0] OFS_IRQ_CLR  = 8'h0C;  // write: clear normal enables
    localparam logic [7:0] OFS_SW_SET   = 8'h10;  // write: set software bits
    localparam logic [7:0] OFS_SW_CLR   = 8'h14;  // write: clear software bits
    localparam logic [7:0] OFS_FIQ_MSK  = 8'h20;  // read: raw & fast enable; write: pass-through word
    localparam logic [7:0] OFS_FIQ_RAW  = 8'h24;  // read: raw status
    localparam logic [7:0] OFS_FIQ_SET  = 8'h28;  // read: fast enable; write: set fast enables
    localparam logic [7:0] OFS_FIQ_CLR  = 8'h2C;  // write: clear fast enables

    // One strobe per write action, at most one high in any cycle.
    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic sw_set;
        logic sw_clr;
        logic fiq_set;
        logic fiq_clr;
        logic pass_load;
    } wr_strobe_t;

endpackage

// File: rtl/irqc_wr_decode.sv
// Module irqc_wr_decode
// Turns a bus write into one action strobe. Assumes bus_addr is a byte
// offset at least 6 bits wide. The pass-through load strobe only exists when
// SECONDARY is set, so in a primary build offset 0x20 is read-only.
module irqc_wr_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter bit          SECONDARY = 1'b1
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    output irqc_pkg::wr_strobe_t strobe
);
    import irqc_pkg::*;

    // Compare the full offset so unaligned and aliased addresses miss.
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    // Decode the set and clear actions that every build carries.
    always_comb begin
        strobe.irq_set = bus_we && hit(bus_addr, OFS_IRQ_SET);
        strobe.irq_clr = bus_we && hit(bus_addr, OFS_IRQ_CLR);
        strobe.sw_set  = bus_we && hit(bus_addr, OFS_SW_SET);
        strobe.sw_clr  = bus_we && hit(bus_addr, OFS_SW_CLR);
        strobe.fiq_set = bus_we && hit(bus_addr, OFS_FIQ_SET);
        strobe.fiq_clr = bus_we && hit(bus_addr, OFS_FIQ_CLR);
    end

    generate
        if (SECONDARY) begin : g_pass_dec
            // Secondary build: 0x20 doubles as the pass-through load address.
            assign strobe.pass_load = bus_we && hit(bus_addr, OFS_FIQ_MSK);
        end else begin : g_no_pass_dec
            // Primary build: no pass-through register to load.
            assign strobe.pass_load = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/irqc_setclr_reg.sv
// Module irqc_setclr_reg
// A register word changed only through write-one-to-set and
// write-one-to-clear strobes. Assumes the two strobes are never high
// together; set wins if they are.
module irqc_setclr_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] q
);

    // Update only the bits that are one in wmask; reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | wmask;
        end else if (clr_en) begin
            q <= q & ~wmask;
        end
    end

endmodule

// File: rtl/irqc_req_out.sv
// Module irqc_req_out
// Masks the shared raw status with one enable word and registers the OR of
// the result as a level request. Assumes raw is already gated by the valid
// mask. The status output is combinational, for the read path.
module irqc_req_out #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] enable,
    output logic [W-1:0] status,
    output logic         req
);

    // Masked status for this output.
    assign status = raw & enable;

    // Register the request so it changes one edge after its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= |status;
        end
    end

endmodule

// File: rtl/irqc_rd_mux.sv
// Module irqc_rd_mux
// Combinational read-data select by byte offset. Offsets that are not
// readable, including unaligned ones, return zero.
module irqc_rd_mux #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      raw,
    input  logic [W-1:0]      irq_status,
    input  logic [W-1:0]      fiq_status,
    input  logic [W-1:0]      fiq_enable,
    output logic [W-1:0]      rdata
);
    import irqc_pkg::*;

    // Select the readable word that matches the offset exactly.
    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(OFS_IRQ_MSK))      rdata = irq_status;
        else if (bus_addr == ADDR_W'(OFS_RAW))     rdata = raw;
        else if (bus_addr == ADDR_W'(OFS_FIQ_MSK)) rdata = fiq_status;
        else if (bus_addr == ADDR_W'(OFS_FIQ_RAW)) rdata = raw;
        else if (bus_addr == ADDR_W'(OFS_FIQ_SET)) rdata = fiq_enable;
    end

endmodule

// File: rtl/irq_fiq_ctrl.sv
// Module irq_fiq_ctrl
// Level-sensitive interrupt controller with two registered requests that
// share one raw status word. Assumes source inputs are synchronous to clk.
// VALID_MASK removes non-existent source positions. SECONDARY adds the
// pass-through word and its combinational output bus.
module irq_fiq_ctrl #(
    parameter int unsigned NSRC       = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [NSRC-1:0] VALID_MASK = '1,
    parameter bit          SECONDARY  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_in,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [NSRC-1:0]   pass_o
);
    import irqc_pkg::*;

    wr_strobe_t      strobe;
    logic [NSRC-1:0] irq_en;
    logic [NSRC-1:0] fiq_en;
    logic [NSRC-1:0] sw_pend;
    logic [NSRC-1:0] pass_en;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] irq_sts;
    logic [NSRC-1:0] fiq_sts;

    irqc_wr_decode #(.ADDR_W(ADDR_W), .SECONDARY(SECONDARY)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .strobe   (strobe)
    );

    irqc_setclr_reg #(.W(NSRC)) u_irq_en (
        .clk (clk), .rst_n (rst_n),
        .set_en (strobe.irq_set), .clr_en (strobe.irq_clr),
        .wmask (bus_wdata), .q (irq_en)
    );

    irqc_setclr_reg #(.W(NSRC)) u_fiq_en (
        .clk (clk), .rst_n (rst_n),
        .set_en (strobe.fiq_set), .clr_en (strobe.fiq_clr),
        .wmask (bus_wdata), .q (fiq_en)
    );

    irqc_setclr_reg #(.W(NSRC)) u_sw (
        .clk (clk), .rst_n (rst_n),
        .set_en (strobe.sw_set), .clr_en (strobe.sw_clr),
        .wmask (bus_wdata), .q (sw_pend)
    );

    // Shared raw status: hardware level OR software bit, valid positions only.
    assign raw = (src_in | sw_pend) & VALID_MASK;

    irqc_req_out #(.W(NSRC)) u_irq_out (
        .clk (clk), .rst_n (rst_n),
        .raw (raw), .enable (irq_en),
        .status (irq_sts), .req (irq_o)
    );

    irqc_req_out #(.W(NSRC)) u_fiq_out (
        .clk (clk), .rst_n (rst_n),
        .raw (raw), .enable (fiq_en),
        .status (fiq_sts), .req (fiq_o)
    );

    generate
        if (SECONDARY) begin : g_pass
            // Load the whole pass-through word on a write to its offset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pass_en <= '0;
                end else if (strobe.pass_load) begin
                    pass_en <= bus_wdata;
                end
            end
        end else begin : g_no_pass
            assign pass_en = '0;
        end
    endgenerate

    // Direct forwarding of valid source lines, bypassing both masks.
    assign pass_o = src_in & VALID_MASK & pass_en;

    irqc_rd_mux #(.ADDR_W(ADDR_W), .W(NSRC)) u_rd (
        .bus_addr   (bus_addr),
        .raw        (raw),
        .irq_status (irq_sts),
        .fiq_status (fiq_sts),
        .fiq_enable (fiq_en),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/irq_fiq_ctrl_sva.sv
// Module irq_fiq_ctrl_sva
// Property checker for irq_fiq_ctrl, bound to every instance. It watches
// the bus, the outputs and the stored words over time.
module irq_fiq_ctrl_sva #(
    parameter int unsigned NSRC       = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [NSRC-1:0] VALID_MASK = '1,
    parameter bit          SECONDARY  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   bus_rdata,
    input logic [NSRC-1:0]   src_in,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [NSRC-1:0]   pass_o,
    input logic [NSRC-1:0]   irq_en,
    input logic [NSRC-1:0]   fiq_en,
    input logic [NSRC-1:0]   sw_pend,
    input logic [NSRC-1:0]   pass_en
);
    logic a_irq_set, a_irq_clr, a_sw_set, a_wr_known, a_status_rd;

    // Independent view of the address map.
    always_comb begin
        a_irq_set   = bus_addr == ADDR_W'(8'h08);
        a_irq_clr   = bus_addr == ADDR_W'(8'h0C);
        a_sw_set    = bus_addr == ADDR_W'(8'h10);
        a_wr_known  = (bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'h0C)) ||
                      (bus_addr == ADDR_W'(8'h10)) || (bus_addr == ADDR_W'(8'h14)) ||
                      (SECONDARY && bus_addr == ADDR_W'(8'h20)) ||
                      (bus_addr == ADDR_W'(8'h28)) || (bus_addr == ADDR_W'(8'h2C));
        a_status_rd = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h04)) ||
                      (bus_addr == ADDR_W'(8'h20)) || (bus_addr == ADDR_W'(8'h24));
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_en == '0 && fiq_en == '0 && sw_pend == '0 &&
                    pass_en == '0 && !irq_o && !fiq_o));

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a_irq_set) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));

    p_irq_clr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a_irq_clr) |=> ((irq_en & $past(bus_wdata)) == '0 &&
                                   (irq_en & ~$past(bus_wdata)) == ($past(irq_en) & ~$past(bus_wdata))));

    p_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a_sw_set) |=> ((sw_pend & $past(bus_wdata)) == $past(bus_wdata)));

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(src_in | sw_pend) & VALID_MASK & $past(irq_en))));

    p_fiq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == |($past(src_in | sw_pend) & VALID_MASK & $past(fiq_en))));

    p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_status_rd |-> ((bus_rdata & ~VALID_MASK) == '0 && (pass_o & ~VALID_MASK) == '0));

    p_pass_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o & ~src_in) == '0);

    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !a_wr_known) |=> ($stable(irq_en) && $stable(fiq_en) &&
                                     $stable(sw_pend) && $stable(pass_en)));

endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_sva #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK), .SECONDARY(SECONDARY)
) u_sva (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_in (src_in),
    .irq_o (irq_o), .fiq_o (fiq_o), .pass_o (pass_o),
    .irq_en (irq_en), .fiq_en (fiq_en), .sw_pend (sw_pend), .pass_en (pass_en)
);

// File: tb/tb_irq_fiq_ctrl.sv
// Bench tb_irq_fiq_ctrl
// Sweeps sources, patterns and offsets against a bench model of the
// requirements. Inputs change and outputs are sampled at the falling edge.
module tb_irq_fiq_ctrl;
    localparam int unsigned NSRC = 32;
    localparam int unsigned AW   = 8;
    localparam logic [31:0] VALID = 32'hFFFF_FF7E;   // positions 0 and 7 absent

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [31:0]     src_in = '0;
    logic            irq_o, fiq_o;
    logic [31:0]     pass_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_irq = '0, m_fiq = '0, m_sw = '0, m_pass = '0;

    always #2 clk = ~clk;   // 250 MHz

    irq_fiq_ctrl #(.NSRC(NSRC), .ADDR_W(AW), .VALID_MASK(VALID), .SECONDARY(1'b1)) dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_in (src_in),
        .irq_o (irq_o), .fiq_o (fiq_o), .pass_o (pass_o)
    );

    function automatic logic [31:0] m_raw();
        return (src_in | m_sw) & VALID;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00:        return m_raw() & m_irq;
            8'h04, 8'h24: return m_raw();
            8'h20:        return m_raw() & m_fiq;
            8'h28:        return m_fiq;
            default:      return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        case (a)
            8'h08: m_irq = m_irq | d;
            8'h0C: m_irq = m_irq & ~d;
            8'h10: m_sw  = m_sw | d;
            8'h14: m_sw  = m_sw & ~d;
            8'h20: m_pass = d;
            8'h28: m_fiq = m_fiq | d;
            8'h2C: m_fiq = m_fiq & ~d;
            default: ;
        endcase
        #1 bus_we = 1'b0;
    endtask

    // Let one edge register the requests, then compare all outputs.
    task automatic chk_out(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " irq_o"}, {31'b0, irq_o}, {31'b0, |(m_raw() & m_irq)});
        chk({tag, " fiq_o"}, {31'b0, fiq_o}, {31'b0, |(m_raw() & m_fiq)});
        chk({tag, " pass_o"}, pass_o, src_in & VALID & m_pass);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: state after reset
        chk_out("R1 reset");
        rd("R1 irq status", 8'h00);
        rd("R1 fiq enable", 8'h28);

        // R2 R8: single source walked, raw at both offsets, no enables
        for (int i = 0; i < 32; i++) begin
            src_in = 32'h1 << i;
            rd("R2 R8 raw 0x04", 8'h04);
            rd("R2 R8 raw 0x24", 8'h24);
        end

        // R3 R4 R11: set and clear patterns, zero bits untouched
        src_in = 32'hFFFF_FFFF;
        wr(8'h08, 32'hA5A5_A5A5); rd("R3 R11 set A5", 8'h00);
        wr(8'h08, 32'h0000_FFFF); rd("R3 set low half", 8'h00);
        wr(8'h0C, 32'h0F0F_0000); rd("R3 clear mixed", 8'h00);
        src_in = 32'h3C3C_C3C3;   rd("R4 masked pattern", 8'h00);
        wr(8'h0C, 32'hFFFF_FFFF); rd("R3 clear all", 8'h00);

        // R7 R8: walk with every normal enable on
        wr(8'h08, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            src_in = 32'h1 << i;
            chk_out("R7 R8 walk");
        end
        src_in = '0;
        chk_out("R7 all low");

        // R5 R8: software bits, including an absent position
        wr(8'h10, 32'h8000_0081); rd("R5 R8 soft set", 8'h04); chk_out("R5 soft req");
        wr(8'h10, 32'h0000_0100); rd("R5 soft set more", 8'h04);
        wr(8'h14, 32'h8000_0000); rd("R5 soft clear", 8'h04); chk_out("R5 soft req clr");
        wr(8'h14, 32'hFFFF_FFFF); rd("R5 soft clear all", 8'h04);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R6: fast enables stored and read back, masked status
        wr(8'h28, 32'h0000_003D); rd("R6 fiq en read", 8'h28);
        src_in = 32'h0000_00F0;   rd("R6 fiq masked", 8'h20); chk_out("R6 fiq req");
        wr(8'h2C, 32'h0000_0030); rd("R6 fiq en clr", 8'h28);
        rd("R6 fiq masked after clr", 8'h20); chk_out("R6 fiq req after clr");

        // R7: fast request lags its source by exactly one edge, no latching
        src_in = '0;
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h28, 32'h0000_0020);
        chk_out("R7 idle");
        @(negedge clk) src_in = 32'h0000_0020;
        #1 chk("R7 before edge", {31'b0, fiq_o}, 32'h0);
        @(posedge clk); #1 chk("R7 after edge", {31'b0, fiq_o}, 32'h1);
        @(negedge clk) src_in = '0;
        #1 chk("R7 drop before edge", {31'b0, fiq_o}, 32'h1);
        @(posedge clk); #1 chk("R7 drop after edge", {31'b0, fiq_o}, 32'h0);

        // R9: pass-through load at 0x20, combinational forwarding
        wr(8'h20, 32'hFFD0_0000);
        rd("R9 fiq en kept", 8'h28);
        @(negedge clk) src_in = 32'hFFFF_FFFF;
        #1 chk("R9 pass comb", pass_o, 32'hFFD0_0000 & VALID);
        src_in = 32'h0050_0080;
        #1 chk("R9 pass subset", pass_o, 32'h0050_0080 & 32'hFFD0_0000 & VALID);
        rd("R9 0x20 reads fiq status", 8'h20);
        wr(8'h20, 32'h0000_0081);
        @(negedge clk) src_in = 32'hFFFF_FFFF;
        #1 chk("R9 R8 pass absent", pass_o, 32'h0);

        // R10: every read offset, then writes to unwritable offsets
        wr(8'h08, 32'h1234_5678);
        wr(8'h10, 32'h0000_0300);
        src_in = 32'h00FF_0000;
        for (int a = 0; a < 256; a++) rd("R10 read sweep", 8'(a));
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h2E, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        src_in = 32'h0;
        rd("R10 irq kept", 8'h00);
        rd("R10 soft kept", 8'h04);
        rd("R10 fiq kept", 8'h28);
        chk_out("R10 outputs kept");
        src_in = 32'hFFFF_FFFF;
        rd("R10 irq kept full", 8'h00);
        chk_out("R10 pass kept");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule